// File: doc/BRIEF.md
# Pipelined Radix-2 Butterfly Stage with Halving or Growth

This block is one stage of a pipelined radix-2 FFT. Each cycle it takes two complex samples, `a` and `b`, and a complex twiddle factor `w`. It multiplies `b` by `w` and returns the pair `x = a + b*w` and `y = a - b*w`. A stage can return to its word size in two ways. In the shifting configuration, a per-sample control bit chosen at run time halves both outputs. In the growth configuration, the output is one bit wider than the input and the control bit is not used. Every width reduction rounds to nearest, with ties going to even. Any result that does not fit the output word is clamped to the nearest end of the range.

A valid strobe and a frame marker travel through the pipeline with the data, so they leave the stage aligned with the samples they came in with. Any clamp sets an overflow flag that stays high until the frame marker clears it. The flag is a health indicator for the whole frame and is not aligned with the sample that caused it. The delay commutators, the twiddle storage and the sequencing between stages sit outside this block.

Top module: `bfly_stage`

## Requirements
- R1: `out_valid` and `out_sync` repeat `in_valid` and `in_sync` exactly LAT = MUL_LAT + ADD_LAT + CONV_LAT clock edges later, and the data produced from a given input appears in that same cycle (defaults 2 + 1 + 1 = 4).
- R2: The twiddle is a signed fraction with CW-1 fraction bits (CW = 18). The product is p_re = rnd((b_re*w_re - b_im*w_im) / 2^(CW-1)) and p_im = rnd((b_re*w_im + b_im*w_re) / 2^(CW-1)), where rnd is the rounding of R8.
- R3: Before the output conversion, x = a + p and y = a - p, computed separately for the real and imaginary parts.
- R4: In the shifting configuration (GROW_EN = 0), a sample that enters with `shift_i` = 1 leaves with all four output parts equal to rnd(value / 2).
- R5: In the shifting configuration, a sample that enters with `shift_i` = 0 is not divided.
- R6: When GROW_EN = 1 and DW < MAX_W, the output is DW+1 bits wide, no halving is applied and `shift_i` has no effect on the output. In every other case the output is DW bits wide.
- R7: At reset, `out_valid`, `out_sync` and `ovf` are 0.
- R8: rnd rounds to the nearest integer and sends exact halves to the even neighbour. For example, 1.5 becomes 2, 2.5 becomes 2, -1.5 becomes -2, 0.5 becomes 0 and -0.5 becomes 0.
- R9: A converted result above the largest OW-bit two's-complement code leaves as that largest code. A result below the smallest code leaves as the smallest code.
- R10: `ovf` rises one cycle after an output cycle that has `out_valid` = 1 and at least one clamped part. A clamp on a sample with valid = 0 does not set `ovf`.
- R11: `ovf` stays at 1 until a cycle with `in_sync` = 1 clears it on the next edge. If a new clamp event falls on the same edge, setting takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input sample is valid |
| in_sync | input | 1 | Frame marker; also clears the overflow flag |
| shift_i | input | 1 | Halve this sample (shifting configuration only) |
| a_re | input | DW | Real part of the upper sample |
| a_im | input | DW | Imaginary part of the upper sample |
| b_re | input | DW | Real part of the lower sample |
| b_im | input | DW | Imaginary part of the lower sample |
| w_re | input | CW | Real part of the twiddle |
| w_im | input | CW | Imaginary part of the twiddle |
| out_valid | output | 1 | Delayed `in_valid` |
| out_sync | output | 1 | Delayed `in_sync` |
| x_re | output | OW | Real part of the sum output |
| x_im | output | OW | Imaginary part of the sum output |
| y_re | output | OW | Real part of the difference output |
| y_im | output | OW | Imaginary part of the difference output |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Exact rounding ties are the hardest cases to reach from the ports. Random twiddles almost never produce a product that lands on a half, so the ties-to-even behaviour at the multiplier would go untested. Directed samples therefore use a twiddle of exactly 0.5 with odd lower samples, and a zero twiddle with odd upper samples while halving is on. A second hard case is a clear marker that arrives on the same edge as a fresh clamp. The stimulus times `in_sync` to fall exactly LAT cycles after a saturating sample, and a stage in the growth configuration receives the same stimulus alongside the shifting one.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Divide by 2^s, rounding to nearest with ties to the even result.
  function automatic longint rnd_even(input longint v, input int s);
    longint keep;
    longint frac;
    longint half;
    if (s <= 0) begin
      keep = v;
    end else begin
      keep = v >>> s;
      frac = v & ((longint'(1) <<< s) - 1);
      half = longint'(1) <<< (s - 1);
      if (frac > half || (frac == half && keep[0])) keep = keep + 1;
    end
    return keep;
  endfunction

  // Clamp into a w-bit two's-complement range; hit reports a clamp.
  function automatic longint clip(input longint v, input int w, output logic hit);
    longint hi;
    longint lo;
    longint r;
    hi  = (longint'(1) <<< (w - 1)) - 1;
    lo  = -(longint'(1) <<< (w - 1));
    hit = 1'b0;
    r   = v;
    if (v > hi) begin
      r   = hi;
      hit = 1'b1;
    end else if (v < lo) begin
      r   = lo;
      hit = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] pipe [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < D; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[D-1];
    end
  endgenerate
endmodule

// File: rtl/bfly_twmul.sv
module bfly_twmul
  import bfly_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CW  = 18,
  parameter int LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [CW-1:0] w_re,
  input  logic signed [CW-1:0] w_im,
  output logic signed [DW+1:0] p_re,
  output logic signed [DW+1:0] p_im
);
  localparam int PW = DW + 2;

  longint          t_re, t_im;
  logic [2*PW-1:0] c_pk, c_out;

  always_comb begin
    t_re = rnd_even(longint'(b_re) * longint'(w_re) - longint'(b_im) * longint'(w_im), CW - 1);
    t_im = rnd_even(longint'(b_re) * longint'(w_im) + longint'(b_im) * longint'(w_re), CW - 1);
    c_pk = {PW'(t_im), PW'(t_re)};
  end

  bfly_delay #(.W(2*PW), .D(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .d(c_pk), .q(c_out)
  );

  assign {p_im, p_re} = c_out;
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 18,
  parameter int MUL_LAT  = 2,
  parameter int ADD_LAT  = 1,
  parameter int CONV_LAT = 1,
  parameter int GROW_EN  = 0,
  parameter int MAX_W    = 18,
  localparam bit GROW_ON = (GROW_EN != 0) && (DW < MAX_W),
  localparam int OW      = GROW_ON ? DW + 1 : DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sync,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [CW-1:0] w_re,
  input  logic signed [CW-1:0] w_im,
  output logic                 out_valid,
  output logic                 out_sync,
  output logic signed [OW-1:0] x_re,
  output logic signed [OW-1:0] x_im,
  output logic signed [OW-1:0] y_re,
  output logic signed [OW-1:0] y_im,
  output logic                 ovf
);
  localparam int PW  = DW + 2;
  localparam int SW  = DW + 3;
  localparam int LAT = MUL_LAT + ADD_LAT + CONV_LAT;

  // twiddle product
  logic signed [PW-1:0] p_re, p_im;
  bfly_twmul #(.DW(DW), .CW(CW), .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst_n(rst_n), .b_re(b_re), .b_im(b_im),
    .w_re(w_re), .w_im(w_im), .p_re(p_re), .p_im(p_im)
  );

  // upper sample and side band aligned to the product
  logic [2*DW+2:0] m_in, m_out;
  logic signed [DW-1:0] ad_re, ad_im;
  logic m_s, m_v, m_sh;
  assign m_in = {in_sync, in_valid, shift_i, a_re, a_im};
  bfly_delay #(.W(2*DW+3), .D(MUL_LAT)) u_dly_a (
    .clk(clk), .rst_n(rst_n), .d(m_in), .q(m_out)
  );
  assign {m_s, m_v, m_sh, ad_re, ad_im} = m_out;

  // sum and difference
  logic signed [SW-1:0] bf [4];
  assign bf[0] = SW'(ad_re) + SW'(p_re);
  assign bf[1] = SW'(ad_im) + SW'(p_im);
  assign bf[2] = SW'(ad_re) - SW'(p_re);
  assign bf[3] = SW'(ad_im) - SW'(p_im);

  logic [4*SW+2:0] s_in, s_out;
  logic signed [SW-1:0] sb [4];
  logic s_s, s_v, s_sh;
  assign s_in = {m_s, m_v, m_sh, bf[3], bf[2], bf[1], bf[0]};
  bfly_delay #(.W(4*SW+3), .D(ADD_LAT)) u_dly_add (
    .clk(clk), .rst_n(rst_n), .d(s_in), .q(s_out)
  );
  assign {s_s, s_v, s_sh, sb[3], sb[2], sb[1], sb[0]} = s_out;

  // width conversion: optional halving, then clamp
  logic signed [OW-1:0] cv [4];
  logic                 sat_c [4];
  for (genvar i = 0; i < 4; i++) begin : g_conv
    always_comb begin
      longint t;
      logic   hit;
      t = longint'(sb[i]);
      if (s_sh && !GROW_ON) t = rnd_even(t, 1);
      t = clip(t, OW, hit);
      cv[i]    = OW'(t);
      sat_c[i] = hit;
    end
  end

  logic [4*OW+5:0] c_in, c_out;
  logic [3:0]      sat_o;
  assign c_in = {s_s, s_v, sat_c[3], sat_c[2], sat_c[1], sat_c[0],
                 cv[3], cv[2], cv[1], cv[0]};
  bfly_delay #(.W(4*OW+6), .D(CONV_LAT)) u_dly_conv (
    .clk(clk), .rst_n(rst_n), .d(c_in), .q(c_out)
  );
  assign {out_sync, out_valid, sat_o, y_im, y_re, x_im, x_re} = c_out;

  // clamp event on a valid output sample
  logic sat_evt;
  assign sat_evt = out_valid & (|sat_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (sat_evt) ovf <= 1'b1;
    else if (in_sync) ovf <= 1'b0;
  end
endmodule

// File: rtl/bfly_stage_chk.sv
module bfly_stage_chk #(
  parameter int LAT = 4,
  parameter int OW  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_sync,
  input logic                 out_valid,
  input logic                 out_sync,
  input logic                 sat_evt,
  input logic                 ovf,
  input logic signed [OW-1:0] x_re,
  input logic signed [OW-1:0] x_im,
  input logic signed [OW-1:0] y_re,
  input logic signed [OW-1:0] y_im
);
  localparam logic signed [OW-1:0] TOP = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] BOT = {1'b1, {(OW-1){1'b0}}};

  logic [15:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_rst <= '0;
    else if (since_rst < 16'(LAT)) since_rst <= since_rst + 16'd1;
  end

  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 16'(LAT)) |-> (!out_valid && !out_sync)); // R1

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ovf); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !in_sync) |=> ovf); // R11

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_evt && in_sync) |=> !ovf); // R11

  AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> (x_re == TOP || x_re == BOT || x_im == TOP || x_im == BOT ||
                 y_re == TOP || y_re == BOT || y_im == TOP || y_im == BOT)); // R9
endmodule

bind bfly_stage bfly_stage_chk #(.LAT(LAT), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .out_valid(out_valid),
  .out_sync(out_sync), .sat_evt(sat_evt), .ovf(ovf),
  .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
);

// File: tb/bfly_stage_tb.sv
`timescale 1ns/1ps
module bfly_stage_tb;
  localparam int DW  = 16;
  localparam int CW  = 18;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sync = 1'b0, shift_i = 1'b0;
  logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic signed [CW-1:0] w_re = '0, w_im = '0;

  logic v0, s0, o0, v1, s1, o1;
  logic signed [DW-1:0] xr0, xi0, yr0, yi0;
  logic signed [DW:0]   xr1, xi1, yr1, yi1;

  bfly_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .shift_i(shift_i),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(v0), .out_sync(s0), .x_re(xr0), .x_im(xi0), .y_re(yr0), .y_im(yi0), .ovf(o0)
  );

  bfly_stage #(.GROW_EN(1), .MAX_W(18)) u_dut_g (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync), .shift_i(shift_i),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .out_valid(v1), .out_sync(s1), .x_re(xr1), .x_im(xi1), .y_re(yr1), .y_im(yi1), .ovf(o1)
  );

  typedef struct {
    bit     v;
    bit     s;
    bit     sat;
    longint e [4];
  } ent_t;

  ent_t q [2][$];
  bit   movf [2];
  int   errs = 0, checks = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // nearest-integer division by 2^s, exact halves to even
  function automatic longint half_even(input longint v, input int s);
    longint unit, qq, r;
    if (s == 0) return v;
    unit = longint'(1) <<< s;
    qq = v >>> s;
    r  = v - qq * unit;
    if (2 * r > unit) qq++;
    else if (2 * r == unit && (qq % 2) != 0) qq++;
    return qq;
  endfunction

  function automatic ent_t model(input bit v, input bit s, input bit sh, input bit grow,
                                 input longint ar, input longint ai, input longint br,
                                 input longint bi, input longint wr, input longint wi);
    ent_t   r;
    longint pr, pi, lim, raw [4];
    int     ow;
    ow  = grow ? DW + 1 : DW;
    lim = longint'(1) <<< (ow - 1);
    pr  = half_even(br * wr - bi * wi, CW - 1);
    pi  = half_even(br * wi + bi * wr, CW - 1);
    raw[0] = ar + pr; raw[1] = ai + pi; raw[2] = ar - pr; raw[3] = ai - pi;
    r.v = v; r.s = s; r.sat = 1'b0;
    for (int k = 0; k < 4; k++) begin
      longint t;
      t = (sh && !grow) ? half_even(raw[k], 1) : raw[k];
      if (t > lim - 1) begin t = lim - 1; r.sat = 1'b1; end
      if (t < -lim)    begin t = -lim;    r.sat = 1'b1; end
      r.e[k] = t;
    end
    return r;
  endfunction

  task automatic observe(input bit next_sync);
    for (int d = 0; d < 2; d++) begin
      longint g [4];
      bit gv, gs, go, evt;
      ent_t e;
      if (d == 0) begin
        g[0] = xr0; g[1] = xi0; g[2] = yr0; g[3] = yi0; gv = v0; gs = s0; go = o0;
      end else begin
        g[0] = xr1; g[1] = xi1; g[2] = yr1; g[3] = yi1; gv = v1; gs = s1; go = o1;
      end
      evt = 1'b0;
      if (q[d].size() == LAT) begin
        e = q[d].pop_front();
        chk(gv == e.v, "R1 valid", longint'(gv), longint'(e.v));
        chk(gs == e.s, "R1 sync", longint'(gs), longint'(e.s));
        if (e.v) begin
          for (int k = 0; k < 4; k++)
            chk(g[k] == e.e[k], d == 0 ? "R2 R3 R4 R5 R8 R9 data" : "R6 R2 R3 R9 grow data",
                g[k], e.e[k]);
          evt = e.sat;
        end
      end else begin
        chk(!gv, "R1 fill", longint'(gv), 0);
      end
      chk(go == movf[d], "R10 R11 ovf", longint'(go), longint'(movf[d]));
      if (evt)            movf[d] = 1'b1;
      else if (next_sync) movf[d] = 1'b0;
    end
  endtask

  task automatic step(input bit v, input bit s, input bit sh,
                      input longint ar, input longint ai, input longint br, input longint bi,
                      input longint wr, input longint wi);
    @(negedge clk);
    observe(s);
    in_valid = v; in_sync = s; shift_i = sh;
    a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
    w_re = CW'(wr); w_im = CW'(wi);
    q[0].push_back(model(v, s, sh, 1'b0, ar, ai, br, bi, wr, wi));
    q[1].push_back(model(v, s, sh, 1'b1, ar, ai, br, bi, wr, wi));
  endtask

  task automatic idle(input bit s);
    step(1'b0, s, 1'b0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic longint rs(input int bits);
    logic [31:0] u;
    u = $urandom();
    return longint'($signed(u)) >>> (32 - bits);
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    movf[0] = 1'b0; movf[1] = 1'b0;
    repeat (4) @(negedge clk);
    // R7: reset state
    chk(!v0 && !s0 && !o0, "R7 reset", longint'({v0, s0, o0}), 0);
    chk(!v1 && !s1 && !o1, "R7 reset grow", longint'({v1, s1, o1}), 0);
    rst_n = 1'b1;

    // R8 ties at the output halving: zero twiddle, odd upper samples
    step(1, 0, 1,  3,  5, 11, 7, 0, 0);
    step(1, 0, 1, -3, -1, 2, 9, 0, 0);
    step(1, 0, 1,  1,  7, 0, 0, 0, 0);
    step(1, 0, 0,  3, -5, 0, 0, 0, 0);     // R5: no halving
    // R8 ties at the product: twiddle 0.5
    step(1, 0, 0, 0, 0, 1, 3, 65536, 0);
    step(1, 0, 0, 0, 0, -1, -3, 65536, 0);
    step(1, 0, 0, 0, 0, 5, 7, 0, 65536);
    // R2: twiddle -1 and near +1
    step(1, 0, 0, 100, -200, -32768, 32767, -131072, 0);
    step(1, 0, 1, 12345, -321, 32767, -32768, 131071, 131071);

    // R9 R10: saturating sample, then idle keeps the flag
    step(1, 0, 0, 32767, -32768, 32767, -32768, 131071, 0);
    repeat (LAT + 3) idle(0);
    idle(1);                               // R11: clear
    repeat (2) idle(0);
    // R10: clamp on an invalid sample must not set the flag
    step(0, 0, 0, 32767, 32767, 32767, 32767, 131071, 0);
    repeat (LAT + 2) idle(0);
    // R11: sync on the same edge as a fresh clamp event
    step(1, 0, 0, -32768, -32768, 32767, 32767, 131071, 0);
    repeat (LAT - 1) idle(0);
    idle(1);
    repeat (3) idle(0);
    idle(1);
    repeat (2) idle(0);

    // random mix, both halving settings
    for (int n = 0; n < 3000; n++) begin
      bit v, s, sh;
      int bits;
      v    = ($urandom() % 8) != 0;
      s    = ($urandom() % 64) == 0;
      sh   = $urandom() % 2;
      bits = (n % 3 == 0) ? 16 : 14;
      step(v, s, sh, rs(bits), rs(bits), rs(bits), rs(bits), rs(CW), rs(CW));
    end
    repeat (LAT + 2) idle(0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule